// File: doc/BRIEF.md
# Latency-Based Issue Interlock Unit

This unit sits at the issue point of an in-order, single-issue pipeline and decides every cycle whether the instruction offered on a valid/ready handshake may issue now or must wait. Each offered instruction arrives already decoded: an operation class, a destination register number and up to two source register numbers, each source with its own enable. The unit keeps one scoreboard entry for each integer register and each FP register. The entry records how recently the register was written and, for FP registers, whether a load or an FP ALU operation wrote it. The unit holds a consumer until the spacing needed between that producer class and that consumer class has elapsed.

The required spacing depends on both sides of the dependence. The data operand of a store has its own rule, so there is no single fixed bubble. A branch has one delay slot that always issues. If nothing is offered in that slot, the unit counts a lost cycle. Two counters report the inserted stall cycles and the number of issued instructions.

Top module: `issue_interlock`

## Requirements
- R1: Class codes are 0 integer ALU, 1 FP ALU, 2 load double, 3 store double, 4 branch, and codes 5 to 7 are treated as no-ops. Integer ops read two integer sources (a, b) and write an integer register. FP ALU ops read two FP sources and write an FP register. Loads read integer source a as their base and write an FP register. Stores read integer source a as their base and FP source b as their data, and write nothing. Branches read integer source a and write nothing. After synchronous reset both counters read zero, no entry is pending and in_ready is 1.
- R2: An FP ALU result consumed by an FP ALU operation forces exactly 3 stall cycles when the consumer directly follows its producer.
- R3: An FP ALU result consumed as store data forces exactly 2 stall cycles.
- R4: A loaded value consumed by an FP ALU operation forces 1 stall cycle. A loaded value consumed as store data forces none.
- R5: An integer result consumed by an integer operation, or used as a load or store base, forces no stall.
- R6: An integer result tested by a directly following branch forces 1 stall cycle.
- R7: The instruction offered in the cycle right after a branch issues is accepted at once (in_ready is 1), even when its sources are still pending.
- R8: If no instruction is offered in the cycle right after a branch issues, that cycle is counted as one stall cycle.
- R9: Only read-after-write dependences stall. A later write to a register that an earlier instruction reads or writes causes no stall. A register rewritten while pending takes the newer producer's class and timing.
- R10: stall_count counts each cycle in which an offered instruction is held, plus each empty delay slot. It saturates at all ones.
- R11: issue_count increments by one for every accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The offered instruction may issue this cycle |
| in_cls | input | 3 | Operation class code |
| in_dst | input | RW | Destination register number |
| in_src_a | input | RW | Source a register number |
| in_src_a_en | input | 1 | Source a is read |
| in_src_b | input | RW | Source b register number |
| in_src_b_en | input | 1 | Source b is read |
| stall_count | output | STALL_W | Saturating count of inserted stall cycles |
| issue_count | output | ISSUE_W | Count of issued instructions |

## Verification
The unit is driven with back-to-back producer/consumer pairs for every class combination that has a rule. This separates the 3, 2, 1 and 0 cycle spacings and shows that the store data operand is judged apart from its base. Further sequences place a branch before a delay slot that is filled with a dependent instruction and before a delay slot that is left empty, which tells the slot exemption apart from the lost-cycle count. Further sequences rewrite a pending register with a load, and write a register right after it is read, which shows that name dependences never stall and that the newest producer governs. A long chain of dependent FP operations drives the stall counter into saturation. A behavioural timestamp model predicts the ready signal and both counters on every cycle.

// File: rtl/issue_interlock.sv
module issue_interlock #(
  parameter int NREG    = 32,
  parameter int STALL_W = 16,
  parameter int ISSUE_W = 32,
  localparam int RW     = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         in_cls,
  input  logic [RW-1:0]      in_dst,
  input  logic [RW-1:0]      in_src_a,
  input  logic               in_src_a_en,
  input  logic [RW-1:0]      in_src_b,
  input  logic               in_src_b_en,
  output logic [STALL_W-1:0] stall_count,
  output logic [ISSUE_W-1:0] issue_count
);
  localparam logic [2:0] C_INT = 3'd0, C_FPU = 3'd1, C_LDD = 3'd2, C_STD = 3'd3, C_BR = 3'd4;
  localparam logic [1:0] HOLD = 2'd3;

  logic [1:0] icd [NREG];
  logic [1:0] fcd [NREG];
  logic       fld [NREG];
  logic       slot;
  logic       ha, hb;

  function automatic logic late(input logic [1:0] cd, input logic [1:0] lat);
    return ({1'b0, cd} + {1'b0, lat}) > 3'd3;
  endfunction

  always_comb begin
    ha = 1'b0;
    hb = 1'b0;
    case (in_cls)
      C_INT: begin
        ha = in_src_a_en && late(icd[in_src_a], 2'd0);
        hb = in_src_b_en && late(icd[in_src_b], 2'd0);
      end
      C_FPU: begin
        ha = in_src_a_en && late(fcd[in_src_a], fld[in_src_a] ? 2'd1 : 2'd3);
        hb = in_src_b_en && late(fcd[in_src_b], fld[in_src_b] ? 2'd1 : 2'd3);
      end
      C_LDD: ha = in_src_a_en && late(icd[in_src_a], 2'd0);
      C_STD: begin
        ha = in_src_a_en && late(icd[in_src_a], 2'd0);
        hb = in_src_b_en && late(fcd[in_src_b], fld[in_src_b] ? 2'd0 : 2'd2);
      end
      C_BR:  ha = in_src_a_en && late(icd[in_src_a], 2'd1);
      default: ;
    endcase
  end

  assign in_ready = slot || !(ha || hb);

  wire issue     = in_valid && in_ready;
  wire stall_evt = (in_valid && !in_ready) || (slot && !in_valid);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        icd[i] <= '0;
        fcd[i] <= '0;
        fld[i] <= 1'b0;
      end
      slot        <= 1'b0;
      stall_count <= '0;
      issue_count <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        icd[i] <= (icd[i] == 2'd0) ? 2'd0 : icd[i] - 2'd1;
        fcd[i] <= (fcd[i] == 2'd0) ? 2'd0 : fcd[i] - 2'd1;
      end
      if (issue) begin
        if (in_cls == C_INT) icd[in_dst] <= HOLD;
        if (in_cls == C_FPU || in_cls == C_LDD) begin
          fcd[in_dst] <= HOLD;
          fld[in_dst] <= (in_cls == C_LDD);
        end
        issue_count <= issue_count + 1'b1;
      end
      slot <= issue && (in_cls == C_BR);
      if (stall_evt && stall_count != '1) stall_count <= stall_count + 1'b1;
    end
  end

  // R10
  stall_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_count == '1) |=> (stall_count == '1));

  // R10
  stall_step_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_count != '1) |=> ((stall_count - $past(stall_count)) <= 1));

  // R11
  issue_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (issue_count == $past(issue_count) + 1'b1));

  // R7
  slot_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_cls == C_BR) |=> in_ready);

  // R2
  fpfp_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_cls == C_FPU) |=>
      !(in_valid && in_ready && in_cls == C_FPU && in_src_a_en && in_src_a == $past(in_dst)));

  // R6
  intbr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_cls == C_INT) |=>
      !(in_valid && in_ready && in_cls == C_BR && in_src_a_en && in_src_a == $past(in_dst)));
endmodule

// File: tb/issue_interlock_test.sv
module issue_interlock_test;
  localparam int C_INT = 0, C_FPU = 1, C_LDD = 2, C_STD = 3, C_BR = 4;

  logic        clk = 0, rst = 1, in_valid = 0;
  logic        in_ready;
  logic [2:0]  in_cls = 0;
  logic [4:0]  in_dst = 0, in_src_a = 0, in_src_b = 0;
  logic        in_src_a_en = 0, in_src_b_en = 0;
  logic [15:0] stall_count;
  logic [31:0] issue_count;

  issue_interlock uut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_a_en(in_src_a_en),
    .in_src_b(in_src_b), .in_src_b_en(in_src_b_en),
    .stall_count(stall_count), .issue_count(issue_count));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc_run = 0;
  string req = "R1";
  int m_it [32], m_ft [32];
  bit m_fl [32];
  int m_cyc = 0, m_stall = 0, m_issue = 0;
  bit m_slot = 0;

  task automatic expect_eq(input string r, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_run++;
    if (cyc_run > 190000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 190000", cyc_run);
      finish_run();
    end
  end

  function automatic bit src_ok(input int tp, input int lat);
    return (m_cyc - tp - 1) >= lat;
  endfunction

  function automatic bit model_ready();
    bit ok = 1;
    if (m_slot) return 1;
    case (int'(in_cls))
      C_INT: begin
        if (in_src_a_en && !src_ok(m_it[in_src_a], 0)) ok = 0;
        if (in_src_b_en && !src_ok(m_it[in_src_b], 0)) ok = 0;
      end
      C_FPU: begin
        if (in_src_a_en && !src_ok(m_ft[in_src_a], m_fl[in_src_a] ? 1 : 3)) ok = 0;
        if (in_src_b_en && !src_ok(m_ft[in_src_b], m_fl[in_src_b] ? 1 : 3)) ok = 0;
      end
      C_LDD: if (in_src_a_en && !src_ok(m_it[in_src_a], 0)) ok = 0;
      C_STD: begin
        if (in_src_a_en && !src_ok(m_it[in_src_a], 0)) ok = 0;
        if (in_src_b_en && !src_ok(m_ft[in_src_b], m_fl[in_src_b] ? 0 : 2)) ok = 0;
      end
      C_BR: if (in_src_a_en && !src_ok(m_it[in_src_a], 1)) ok = 0;
      default: ;
    endcase
    return ok;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin m_it[i] = -100; m_ft[i] = -100; m_fl[i] = 0; end
    m_cyc = 0; m_stall = 0; m_issue = 0; m_slot = 0;
  endtask

  task automatic tick(output bit issued);
    bit rdy = model_ready();
    expect_eq(req, "in_ready", in_ready, rdy);
    expect_eq(req, "stall_count", stall_count, m_stall);
    expect_eq(req, "issue_count", issue_count, m_issue);
    issued = in_valid && rdy;
    if ((in_valid && !rdy) || (m_slot && !in_valid)) m_stall = (m_stall < 65535) ? m_stall + 1 : 65535;
    if (issued) begin
      m_issue++;
      if (in_cls == C_INT) m_it[in_dst] = m_cyc;
      if (in_cls == C_FPU || in_cls == C_LDD) begin
        m_ft[in_dst] = m_cyc;
        m_fl[in_dst] = (in_cls == C_LDD);
      end
    end
    m_slot = issued && (in_cls == C_BR);
    m_cyc++;
  endtask

  task automatic present(input int c, input int d, input int a, input bit ae, input int b, input bit be);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      in_valid = 1; in_cls = 3'(c); in_dst = 5'(d);
      in_src_a = 5'(a); in_src_a_en = ae; in_src_b = 5'(b); in_src_b_en = be;
      #1 tick(done);
    end
  endtask

  task automatic idle(input int n);
    bit d;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
      #1 tick(d);
    end
  endtask

  task automatic seg_check(input string r, input int s0, input int exp);
    @(negedge clk);
    in_valid = 0;
    #1 expect_eq(r, "stall delta", int'(stall_count) - s0, exp);
    begin bit d; tick(d); end
  endtask

  initial begin
    int s0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    req = "R1";
    expect_eq("R1", "reset stall_count", stall_count, 0);
    expect_eq("R1", "reset issue_count", issue_count, 0);
    expect_eq("R1", "reset in_ready", in_ready, 1);
    begin bit d; tick(d); end

    req = "R2"; s0 = stall_count;
    present(C_FPU, 4, 0, 1, 2, 1); present(C_FPU, 5, 4, 1, 2, 1);
    seg_check("R2", s0, 3); idle(4);

    req = "R3"; s0 = stall_count;
    present(C_FPU, 6, 0, 1, 2, 1); present(C_STD, 0, 1, 1, 6, 1);
    seg_check("R3", s0, 2); idle(4);

    req = "R4"; s0 = stall_count;
    present(C_LDD, 8, 1, 1, 0, 0); present(C_FPU, 9, 8, 1, 2, 1);
    seg_check("R4", s0, 1); idle(4);
    s0 = stall_count;
    present(C_LDD, 10, 1, 1, 0, 0); present(C_STD, 0, 1, 1, 10, 1);
    seg_check("R4", s0, 0); idle(4);

    req = "R5"; s0 = stall_count;
    present(C_INT, 3, 1, 1, 2, 1); present(C_INT, 7, 3, 1, 3, 1);
    present(C_LDD, 11, 7, 1, 0, 0); present(C_INT, 12, 1, 1, 0, 0);
    present(C_STD, 0, 12, 1, 11, 0);
    seg_check("R5", s0, 0); idle(4);

    req = "R6"; s0 = stall_count;
    present(C_INT, 13, 1, 1, 2, 1); present(C_BR, 0, 13, 1, 0, 0);
    present(C_INT, 14, 1, 1, 0, 0);
    seg_check("R6", s0, 1); idle(4);

    req = "R7"; s0 = stall_count;
    present(C_FPU, 15, 0, 1, 2, 1); present(C_BR, 0, 1, 1, 0, 0);
    present(C_FPU, 16, 15, 1, 2, 1);
    seg_check("R7", s0, 0); idle(4);

    req = "R8"; s0 = stall_count;
    present(C_BR, 0, 1, 1, 0, 0); idle(1);
    seg_check("R8", s0, 1); idle(4);

    req = "R9"; s0 = stall_count;
    present(C_FPU, 17, 0, 1, 2, 1); present(C_LDD, 17, 1, 1, 0, 0);
    present(C_FPU, 18, 17, 1, 0, 0);
    present(C_FPU, 19, 20, 1, 21, 1); present(C_LDD, 20, 1, 1, 0, 0);
    seg_check("R9", s0, 1); idle(4);

    req = "R11";
    s0 = issue_count;
    present(C_INT, 22, 1, 1, 0, 0); present(C_INT, 23, 1, 1, 0, 0); present(5, 0, 0, 0, 0, 0);
    @(negedge clk); in_valid = 0; #1;
    expect_eq("R11", "issue delta", int'(issue_count) - s0, 3);
    begin bit d; tick(d); end
    idle(4);

    req = "R10";
    for (int i = 0; i < 22000; i++) present(C_FPU, 1, 1, 1, 1, 1);
    idle(4);
    @(negedge clk); #1;
    expect_eq("R10", "saturated stall_count", stall_count, 65535);
    present(C_FPU, 1, 1, 1, 1, 1); present(C_FPU, 1, 1, 1, 1, 1);
    idle(2);
    @(negedge clk); #1;
    expect_eq("R10", "held at saturation", stall_count, 65535);
    finish_run();
  end
endmodule